// File: doc/BRIEF.md
# Burst-Fill Data Cache Controller

This block is a direct-mapped data cache that sits between a processor's load/store port and a 32-bit main-memory bus. Each line holds four 32-bit words, and the cache stores 2048 data words in total across 512 lines. Tag and valid state sit in separate storage and are not counted in that total. When a load misses, the controller requests the whole line once and then accepts it as a burst of consecutive words. Each word arrives on the 32-bit data path and is qualified by a data-valid strobe. The processor is held stalled until the line is complete.

Stores are write-through. Every store becomes one single-word write on the memory bus, and the processor waits for the memory acknowledge. A store that hits also merges its enabled bytes into the cached word. A store that misses leaves the cache untouched. Loads that hit return data in the cycle they are presented, with no stall.

Top module: `burst_dcache`

## Requirements
- R1: After reset every line is invalid. The first load to any address misses, and with no request present `cpu_stall` and `mem_req` are both low.
- R2: A load miss produces exactly one read transaction. `mem_req`=1 and `mem_we`=0, with `mem_addr` equal to the line base address (the load address with bits 3:0 cleared). Request and address stay steady until `mem_ack`.
- R3: After the acknowledge, the line arrives as four beats marked by `mem_rvalid`. They are stored as words 0,1,2,3 of the line in that order. Cycles with `mem_rvalid` low between beats are waited out.
- R4: `cpu_stall` is high from the cycle the miss is seen through the cycle of the last beat. In the following cycle it is low and `cpu_rdata` holds the requested word. With acknowledge latency L and no gaps, a load miss stalls for 6+L cycles.
- R5: A load that hits returns the word with `cpu_stall` low in the same cycle and issues no memory request. `cpu_be` has no effect on loads.
- R6: The address splits into byte offset 1:0, word select 3:2, line index 12:4 and tag 31:13. Two addresses that differ only in bits 31:13 share a line, so filling one evicts the other.
- R7: A store drives `mem_req`=1 and `mem_we`=1, with the processor's address, data and byte enables. `cpu_stall` stays high until the cycle in which `mem_ack` is high, so acknowledge latency L gives L stall cycles.
- R8: A store that hits updates exactly the cached bytes whose enable bit is set (bit n covers data bits 8n+7:8n). A later load hit sees the merged word.
- R9: A store that misses allocates nothing. A later load to that address still misses and fetches the line from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = single-word write, 0 = line burst read |
| mem_addr | output | 32 | Transaction byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The hardest case to produce from the ports is a fill that replaces a valid line belonging to a different tag. The bench reaches it by loading addresses that differ only above bit 12, and then returning to the first address to prove it was evicted. Burst timing is the other hard area. The bench's memory model can add acknowledge latency and can insert an idle cycle after each beat, so the beat counter must ignore gaps. The exact stall length of each miss is checked against the count worked out from those settings. A store is issued between its own miss and a later load to show that nothing was allocated.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_ASK  = 2'd1,
      FILL_BEAT = 2'd2
   } fill_state_e;

   localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/bdc_tag_store.sv
module bdc_tag_store #(
   parameter  int unsigned NUM_LINES = 512,
   parameter  int unsigned TAG_W     = 19,
   localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_valid_o,
   output logic [TAG_W-1:0] rd_tag_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i
);
   logic [NUM_LINES-1:0] valid_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en_i) begin
         valid_q[wr_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_q[wr_idx_i] <= wr_tag_i;
      end
   end

   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_tag_o   = tag_q[rd_idx_i];

   AST_VALID_ONLY_BY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> valid_q == $past(valid_q)); // R9
endmodule

// File: rtl/bdc_data_store.sv
module bdc_data_store #(
   parameter  int unsigned NUM_LINES      = 512,
   parameter  int unsigned WORDS_PER_LINE = 4,
   parameter  int unsigned DATA_W         = 32,
   localparam int unsigned LANES          = DATA_W / bdc_pkg::LANE_BITS,
   localparam int unsigned DEPTH          = NUM_LINES * WORDS_PER_LINE,
   localparam int unsigned AW             = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [LANES-1:0]  wr_be_i,
   input  logic [DATA_W-1:0] wr_data_i
);
   localparam int unsigned LB = bdc_pkg::LANE_BITS;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LB-1:0] lane_q [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en_i && wr_be_i[g]) begin
            lane_q[wr_addr_i] <= wr_data_i[g*LB +: LB];
         end
      end

      assign rd_data_o[g*LB +: LB] = lane_q[rd_addr_i];
   end
endmodule

// File: rtl/bdc_fill_ctrl.sv
module bdc_fill_ctrl
   import bdc_pkg::*;
#(
   parameter  int unsigned LINE_ADDR_W    = 28,
   parameter  int unsigned WORDS_PER_LINE = 4,
   localparam int unsigned WSEL_W         = $clog2(WORDS_PER_LINE)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LINE_ADDR_W-1:0] line_i,
   input  logic                   ack_i,
   input  logic                   rvalid_i,
   output logic                   busy_o,
   output logic                   ask_o,
   output logic [LINE_ADDR_W-1:0] line_o,
   output logic                   beat_we_o,
   output logic [WSEL_W-1:0]      beat_sel_o,
   output logic                   done_o
);
   localparam logic [WSEL_W-1:0] LAST_SEL = WSEL_W'(WORDS_PER_LINE - 1);

   fill_state_e            state_q;
   logic [LINE_ADDR_W-1:0] line_q;
   logic [WSEL_W-1:0]      sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FILL_IDLE;
         line_q  <= '0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            FILL_IDLE: begin
               if (start_i) begin
                  state_q <= FILL_ASK;
                  line_q  <= line_i;
               end
            end
            FILL_ASK: begin
               if (ack_i) begin
                  state_q <= FILL_BEAT;
                  sel_q   <= '0;
               end
            end
            FILL_BEAT: begin
               if (rvalid_i) begin
                  sel_q <= sel_q + 1'b1;
                  if (sel_q == LAST_SEL) begin
                     state_q <= FILL_IDLE;
                  end
               end
            end
            default: state_q <= FILL_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != FILL_IDLE);
   assign ask_o      = (state_q == FILL_ASK);
   assign line_o     = line_q;
   assign beat_we_o  = (state_q == FILL_BEAT) && rvalid_i;
   assign beat_sel_o = sel_q;
   assign done_o     = beat_we_o && (sel_q == LAST_SEL);

   AST_ASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ask_o && !ack_i |=> ask_o && $stable(line_o)); // R2

   AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R4

   AST_BEAT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      beat_we_o && !done_o |=> busy_o && (beat_sel_o == WSEL_W'($past(beat_sel_o) + 1'b1))); // R3
endmodule

// File: rtl/burst_dcache.sv
module burst_dcache
   import bdc_pkg::*;
#(
   parameter  int unsigned ADDR_W         = 32,
   parameter  int unsigned DATA_W         = 32,
   parameter  int unsigned WORDS_PER_LINE = 4,
   parameter  int unsigned NUM_LINES      = 512,
   localparam int unsigned BE_W           = DATA_W / LANE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_be,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int unsigned BOFF_W      = $clog2(BE_W);
   localparam int unsigned WSEL_W      = $clog2(WORDS_PER_LINE);
   localparam int unsigned IDX_W       = $clog2(NUM_LINES);
   localparam int unsigned LOFF_W      = BOFF_W + WSEL_W;
   localparam int unsigned TAG_W       = ADDR_W - IDX_W - LOFF_W;
   localparam int unsigned LINE_ADDR_W = ADDR_W - LOFF_W;
   localparam int unsigned DS_AW       = IDX_W + WSEL_W;

   // address split of the processor request
   logic [WSEL_W-1:0] req_sel;
   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   assign req_sel = cpu_addr[BOFF_W +: WSEL_W];
   assign req_idx = cpu_addr[LOFF_W +: IDX_W];
   assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   // tag lookup
   logic             line_valid;
   logic [TAG_W-1:0] line_tag;
   logic             tag_hit;
   assign tag_hit = line_valid && (line_tag == req_tag);

   // fill sequencer
   logic                   fill_busy, fill_ask, fill_done, beat_we;
   logic [LINE_ADDR_W-1:0] fill_line;
   logic [WSEL_W-1:0]      beat_sel;
   logic [IDX_W-1:0]       fill_idx;
   logic [TAG_W-1:0]       fill_tag;
   assign fill_idx = fill_line[IDX_W-1:0];
   assign fill_tag = fill_line[LINE_ADDR_W-1 -: TAG_W];

   logic load_go, store_go, miss_go, store_hit_wr;
   assign load_go      = cpu_req && !cpu_we && !fill_busy;
   assign store_go     = cpu_req &&  cpu_we && !fill_busy;
   assign miss_go      = load_go && !tag_hit;
   assign store_hit_wr = store_go && mem_ack && tag_hit;

   bdc_fill_ctrl #(
      .LINE_ADDR_W   (LINE_ADDR_W),
      .WORDS_PER_LINE(WORDS_PER_LINE)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (miss_go),
      .line_i    (cpu_addr[ADDR_W-1 -: LINE_ADDR_W]),
      .ack_i     (mem_ack),
      .rvalid_i  (mem_rvalid),
      .busy_o    (fill_busy),
      .ask_o     (fill_ask),
      .line_o    (fill_line),
      .beat_we_o (beat_we),
      .beat_sel_o(beat_sel),
      .done_o    (fill_done)
   );

   bdc_tag_store #(
      .NUM_LINES(NUM_LINES),
      .TAG_W    (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx_i  (req_idx),
      .rd_valid_o(line_valid),
      .rd_tag_o  (line_tag),
      .wr_en_i   (fill_done),
      .wr_idx_i  (fill_idx),
      .wr_tag_i  (fill_tag)
   );

   // data array write port: burst beats take priority, stores only when idle
   logic              ds_we;
   logic [DS_AW-1:0]  ds_waddr;
   logic [BE_W-1:0]   ds_be;
   logic [DATA_W-1:0] ds_wdata;

   always_comb begin
      ds_we    = beat_we || store_hit_wr;
      ds_waddr = {req_idx, req_sel};
      ds_be    = cpu_be;
      ds_wdata = cpu_wdata;
      if (beat_we) begin
         ds_waddr = {fill_idx, beat_sel};
         ds_be    = '1;
         ds_wdata = mem_rdata;
      end
   end

   bdc_data_store #(
      .NUM_LINES     (NUM_LINES),
      .WORDS_PER_LINE(WORDS_PER_LINE),
      .DATA_W        (DATA_W)
   ) u_data (
      .clk      (clk),
      .rd_addr_i({req_idx, req_sel}),
      .rd_data_o(cpu_rdata),
      .wr_en_i  (ds_we),
      .wr_addr_i(ds_waddr),
      .wr_be_i  (ds_be),
      .wr_data_i(ds_wdata)
   );

   // processor and memory side outputs
   assign cpu_stall = fill_busy || miss_go || (store_go && !mem_ack);
   assign mem_req   = fill_ask || store_go;
   assign mem_we    = store_go;
   assign mem_addr  = fill_ask ? {fill_line, {LOFF_W{1'b0}}} : cpu_addr;
   assign mem_wdata = cpu_wdata;
   assign mem_be    = store_go ? cpu_be : '1;

   AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !fill_busy && tag_hit |-> !cpu_stall && !mem_req); // R5

   AST_STORE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && !cpu_stall |-> mem_ack && mem_we); // R7

   AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_addr[LOFF_W-1:0] == '0); // R2

   AST_MISS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_busy) |-> $past(cpu_stall)); // R4
endmodule

// File: tb/burst_dcache_bench.sv
`timescale 1ns/1ps
module burst_dcache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack, mem_rvalid;
   logic [31:0] mem_rdata;

   always #2.5 clk = ~clk;

   burst_dcache u_burst_dcache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int   n_chk = 0, n_bad = 0;
   int   mem_lat = 0;
   bit   gap_mode = 1'b0;
   int   rd_txn = 0, wr_txn = 0;
   logic [31:0] last_rd_addr = '0;
   logic [31:0] bmem [logic [29:0]];

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (bmem.exists(a[31:2])) return bmem[a[31:2]];
      return {2'b10, a[31:2]} ^ 32'h3C3C_0F0F;
   endfunction

   // memory model: evaluates at the falling edge
   initial begin : mem_model
      int wait_cnt, beats_left;
      logic [31:0] baddr, w;
      bit skip;
      wait_cnt = 0; beats_left = 0; baddr = '0; skip = 1'b0;
      mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         mem_rvalid = 1'b0;
         if (!rst_n) begin
            wait_cnt = 0; beats_left = 0;
         end else if (beats_left > 0) begin
            if (skip) skip = 1'b0;
            else begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_word(baddr);
               baddr      = baddr + 32'd4;
               beats_left = beats_left - 1;
               skip       = gap_mode;
            end
         end else if (mem_req) begin
            if (wait_cnt < mem_lat) wait_cnt = wait_cnt + 1;
            else begin
               wait_cnt = 0;
               mem_ack  = 1'b1;
               if (mem_we) begin
                  w = mem_word(mem_addr);
                  for (int b = 0; b < 4; b++)
                     if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
                  bmem[mem_addr[31:2]] = w;
                  wr_txn = wr_txn + 1;
               end else begin
                  beats_left   = 4;
                  baddr        = mem_addr;
                  skip         = 1'b0;
                  rd_txn       = rd_txn + 1;
                  last_rd_addr = mem_addr;
               end
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                         input logic [3:0] be, output logic [31:0] rd, output int cyc);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      cyc = 0;
      #3;
      while (cpu_stall && cyc < 200) begin
         cyc = cyc + 1;
         @(posedge clk); #4;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  be;
      logic [7:0]  cyc;
      logic [15:0] tag;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h0000_1238, 32'h0, 4'hF, 8'd6, "R1"},
      '{1'b0, 32'h0000_1230, 32'h0, 4'hF, 8'd0, "R5"},
      '{1'b0, 32'h0000_123C, 32'h0, 4'hF, 8'd0, "R3"},
      '{1'b0, 32'h0000_1234, 32'h0, 4'h0, 8'd0, "R5"},
      '{1'b1, 32'h0000_1234, 32'hDEAD_BEEF, 4'h5, 8'd0, "R7"},
      '{1'b0, 32'h0000_1234, 32'h0, 4'hF, 8'd0, "R8"},
      '{1'b1, 32'h4000_0040, 32'hCAFE_F00D, 4'hF, 8'd0, "R9"},
      '{1'b0, 32'h4000_0040, 32'h0, 4'hF, 8'd6, "R9"},
      '{1'b0, 32'h0000_3230, 32'h0, 4'hF, 8'd6, "R6"},
      '{1'b0, 32'h0000_1230, 32'h0, 4'hF, 8'd6, "R6"},
      '{1'b0, 32'h0000_3234, 32'h0, 4'hF, 8'd6, "R6"},
      '{1'b0, 32'h0000_1FF0, 32'h0, 4'hF, 8'd6, "R6"},
      '{1'b0, 32'h0000_1FFC, 32'h0, 4'hF, 8'd0, "R6"},
      '{1'b1, 32'h0000_1FF8, 32'h1234_5678, 4'h8, 8'd0, "R8"},
      '{1'b0, 32'h0000_1FF8, 32'h0, 4'hF, 8'd0, "R8"},
      '{1'b0, 32'h0000_2000, 32'h0, 4'hF, 8'd6, "R6"},
      '{1'b0, 32'h0000_0000, 32'h0, 4'hF, 8'd6, "R6"}
   };

   initial begin : watchdog
      #(200000 * 5);
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int cyc, r0, w0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: quiet outputs right after reset
      @(posedge clk); #4;
      check("R1 stall idle", {31'b0, cpu_stall}, 32'd0);
      check("R1 mem_req idle", {31'b0, mem_req}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         r0 = rd_txn; w0 = wr_txn;
         access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].be, rd, cyc);
         check({string'(VEC[i].tag), " stall cycles"}, cyc, {24'b0, VEC[i].cyc});
         check({string'(VEC[i].tag), " write txns"}, wr_txn - w0, {31'b0, VEC[i].we});
         if (!VEC[i].we) begin
            check({string'(VEC[i].tag), " load data"}, rd, mem_word(VEC[i].addr));
            check({string'(VEC[i].tag), " R2 read txns"}, rd_txn - r0,
                  (VEC[i].cyc != 0) ? 32'd1 : 32'd0);
            if (VEC[i].cyc != 0)
               check({string'(VEC[i].tag), " R2 burst base"}, last_rd_addr,
                     VEC[i].addr & 32'hFFFF_FFF0);
         end
      end

      // R4: acknowledge latency lengthens the miss stall
      mem_lat = 3;
      access(1'b0, 32'h0000_5008, 32'h0, 4'hF, rd, cyc);
      check("R4 stall with latency", cyc, 32'd9);
      check("R4 data after fill", rd, mem_word(32'h0000_5008));

      // R7: store waits for a late acknowledge
      mem_lat = 2;
      access(1'b1, 32'h0000_5004, 32'hA1B2_C3D4, 4'h6, rd, cyc);
      check("R7 store stall", cyc, 32'd2);
      mem_lat = 0;
      access(1'b0, 32'h0000_5004, 32'h0, 4'hF, rd, cyc);
      check("R8 merged after late store", rd, mem_word(32'h0000_5004));
      check("R8 hit after store", cyc, 32'd0);

      // R3: gaps between beats
      gap_mode = 1'b1;
      access(1'b0, 32'h0000_6014, 32'h0, 4'hF, rd, cyc);
      check("R3 stall with gaps", cyc, 32'd9);
      check("R3 data with gaps", rd, mem_word(32'h0000_6014));
      gap_mode = 1'b0;
      access(1'b0, 32'h0000_6010, 32'h0, 4'hF, rd, cyc);
      check("R3 word0 after gaps", rd, mem_word(32'h0000_6010));
      access(1'b0, 32'h0000_601C, 32'h0, 4'hF, rd, cyc);
      check("R3 word3 after gaps", rd, mem_word(32'h0000_601C));
      check("R3 word3 hit", cyc, 32'd0);

      // R1: reset mid-run invalidates lines that were hitting
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      r0 = rd_txn;
      access(1'b0, 32'h0000_1FFC, 32'h0, 4'hF, rd, cyc);
      check("R1 miss after reset", cyc, 32'd6);
      check("R1 refetch after reset", rd_txn - r0, 32'd1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule